// File: doc/BRIEF.md
# Multi-Mode Timer Channel Unit

This block is a general-purpose timer. A single counter of parameterised width is shared by a parameterised number of channels. Each channel works on its own as an edge-triggered capture unit, as a compare unit that acts on its pin, or as an edge-aligned pulse-width generator. A global switch changes the counter into an up/down counter. In that state every channel produces a center-aligned pulse-width output instead, and its per-channel mode field is ignored.

The counter's clock is chosen by a two-bit source field. One code runs it from the bus clock. Another runs it from an external clock, which is synchronised in the bus domain and edge-detected into a count enable. The remaining codes stop it. A channel drives its pin only while the source field is nonzero and its own edge/level field is nonzero. Otherwise the output-enable is low and the pad returns to general-purpose I/O. Registers are plain ports: the compare/capture values are written through a strobe, and the sticky flags are cleared through pulse inputs.

Top module: `tpm_unit`

## Requirements
- R1: Clock source `clk_sel` 00 and 10 stop the counter. 01 advances it on every bus clock. 11 advances it once per rising edge of `ext_clk`, after a two-flop synchroniser and an edge detector: a rise first sampled at bus edge k moves the counter at bus edge k+2.
- R2: With `center_mode` low, each enabled count step moves the counter up by one. A step taken while the count is at or above `modulo` loads 0 and sets the overflow flag.
- R3: With `center_mode` high, the counter counts up until it reaches `modulo` or more, and then counts down. A step taken at 0 while counting down reverses it to 1 and sets the overflow flag. When `modulo` is 0, the count stays at 0 and every step sets the overflow flag.
- R4: The overflow flag and the channel flags are sticky. They clear on a cycle where their clear input is high, and a new event in that same cycle wins over the clear.
- R5: `ch_pin_oe[i]` is high exactly when `clk_sel` is nonzero and that channel's edge/level field is nonzero.
- R6: Capture (center mode off, mode 00, edge/level nonzero) uses the edge/level field as follows: 01 = rising, 10 = falling, 11 = both edges. The pin is synchronised by two flops. On a selected edge, the current count is loaded into the value register and the flag is set. A capture takes priority over a software write in the same cycle.
- R7: Compare (mode 01) acts on a count step where the count equals the value. It sets the flag, and the pin toggles, clears or sets for edge/level 01, 10 or 11. With edge/level 00, only the flag is set.
- R8: Edge-aligned PWM (mode 10 or 11): on a wrap step, the pin goes to the inverse of edge/level bit 0. On a match step that is not also a wrap, the pin goes to bit 0. A match also sets the flag.
- R9: In center mode, every match step toggles the pin and sets the flag, whether the counter is going up or down. No capture happens in center mode.
- R10: A pulse on `ch_val_we[i]` loads the channel's slice of `ch_val_wdata` into its value register on that clock edge.
- R11: After reset, the count, all flags, pins and values are 0 and the counter's direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Counter clock source |
| center_mode | input | 1 | Global center-aligned (up/down) mode |
| ext_clk | input | 1 | External count clock, at most a quarter of the bus rate |
| modulo | input | W | Counter end value |
| count | output | W | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| ch_mode | input | 2*NCH | Per-channel mode field |
| ch_edge | input | 2*NCH | Per-channel edge/level field |
| ch_val_we | input | NCH | Per-channel value write strobe |
| ch_val_wdata | input | NCH*W | Per-channel value write data |
| ch_val | output | NCH*W | Per-channel value registers |
| ch_flag | output | NCH | Per-channel sticky flags |
| ch_flag_clr | input | NCH | Per-channel flag clear |
| ch_pin_in | input | NCH | Channel pin inputs |
| ch_pin_out | output | NCH | Channel pin outputs |
| ch_pin_oe | output | NCH | Channel pin output-enables |

## Verification
The channels are run side by side under the following configurations:
- an up-count period of ten;
- a later cut of `modulo` below the running count, which must force an immediate wrap;
- an up/down period with a modulo of 7;
- a zero modulo in both counter modes;
- the external clock source;
- both stopped source codes.

The compare unit steps through toggle, clear, set and flag-only actions. The two PWM polarities run together, so an inverted level would show up as a pair of outputs that mirror each other. Capture is fed isolated rising and falling pulses under each edge selection, so a wrong edge decode shows up as a missed or extra latch. It is also fed back-to-back toggles together with software writes, which separates capture priority from write priority. Input toggles during center mode must leave the value registers unchanged.

// File: rtl/tpm_unit.sv
module tpm_unit #(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         clk_sel,
  input  logic               center_mode,
  input  logic               ext_clk,
  input  logic [W-1:0]       modulo,
  output logic [W-1:0]       count,
  output logic               ovf_flag,
  input  logic               ovf_clr,
  input  logic [2*NCH-1:0]   ch_mode,
  input  logic [2*NCH-1:0]   ch_edge,
  input  logic [NCH-1:0]     ch_val_we,
  input  logic [NCH*W-1:0]   ch_val_wdata,
  output logic [NCH*W-1:0]   ch_val,
  output logic [NCH-1:0]     ch_flag,
  input  logic [NCH-1:0]     ch_flag_clr,
  input  logic [NCH-1:0]     ch_pin_in,
  output logic [NCH-1:0]     ch_pin_out,
  output logic [NCH-1:0]     ch_pin_oe
);

  logic [2:0] ext_sync;
  logic       dir_down;

  wire ext_step = ext_sync[1] & ~ext_sync[2];
  wire tick     = (clk_sel == 2'b01) | ((clk_sel == 2'b11) & ext_step);
  wire at_top   = count >= modulo;
  wire at_bot   = count == '0;
  wire wrap_up  = tick & ~center_mode & at_top;
  wire ovf_evt  = tick & (center_mode ? ((modulo == '0) | (dir_down & at_bot)) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else begin
      if (!center_mode) dir_down <= 1'b0;
      if (tick) begin
        if (!center_mode) begin
          count <= at_top ? '0 : count + 1'b1;
        end else if (modulo == '0) begin
          count    <= '0;
          dir_down <= 1'b0;
        end else if (!dir_down) begin
          if (at_top) begin
            dir_down <= 1'b1;
            count    <= count - 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else if (at_bot) begin
          dir_down <= 1'b0;
          count    <= {{(W-1){1'b0}}, 1'b1};
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0]   md, el;
    logic [W-1:0] val;
    logic [2:0]   psync;
    logic         pin, pin_nx, flg;

    assign md = ch_mode[2*i +: 2];
    assign el = ch_edge[2*i +: 2];

    wire owned = (clk_sel != 2'b00) & (el != 2'b00);
    wire rise  = psync[1] & ~psync[2];
    wire fall  = ~psync[1] & psync[2];
    wire match = tick & (count == val);
    wire cap   = ~center_mode & (md == 2'b00) & owned & ((el[0] & rise) | (el[1] & fall));
    wire hit   = cap | (match & (center_mode | (md != 2'b00)));

    always_comb begin
      pin_nx = pin;
      if (center_mode) begin
        if (match) pin_nx = ~pin;
      end else if (md == 2'b01) begin
        if (match) begin
          case (el)
            2'b01:   pin_nx = ~pin;
            2'b10:   pin_nx = 1'b0;
            2'b11:   pin_nx = 1'b1;
            default: pin_nx = pin;
          endcase
        end
      end else if (md[1]) begin
        if (wrap_up)    pin_nx = ~el[0];
        else if (match) pin_nx = el[0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        psync <= '0;
        pin   <= 1'b0;
        flg   <= 1'b0;
        val   <= '0;
      end else begin
        psync <= {psync[1:0], ch_pin_in[i]};
        pin   <= pin_nx;
        flg   <= hit | (flg & ~ch_flag_clr[i]);
        if (cap)                val <= count;
        else if (ch_val_we[i])  val <= ch_val_wdata[i*W +: W];
      end
    end

    assign ch_val[i*W +: W] = val;
    assign ch_flag[i]       = flg;
    assign ch_pin_out[i]    = pin;
    assign ch_pin_oe[i]     = owned;
  end

endmodule

module tpm_unit_chk #(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       clk_sel,
  input logic             center_mode,
  input logic [W-1:0]     modulo,
  input logic [W-1:0]     count,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic [NCH-1:0]   ch_val_we,
  input logic [NCH*W-1:0] ch_val,
  input logic [NCH-1:0]   ch_pin_oe,
  input logic             dir_down
);

  a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00) |=> $stable(count));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!center_mode && clk_sel == 2'b01 && count >= modulo) |=> (count == '0 && ovf_flag));

  a_r3_turn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && clk_sel == 2'b01 && dir_down && count == '0) |=> (ovf_flag && count <= 1));

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r5_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00) |-> (ch_pin_oe == '0));

  a_r9_no_capture_centered: assert property (@(posedge clk) disable iff (!rst_n)
    (center_mode && ch_val_we == '0) |=> $stable(ch_val));

endmodule

bind tpm_unit tpm_unit_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .center_mode(center_mode),
  .modulo(modulo), .count(count), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
  .ch_val_we(ch_val_we), .ch_val(ch_val), .ch_pin_oe(ch_pin_oe), .dir_down(dir_down)
);

// File: tb/tpm_unit_test.sv
`timescale 1ns/1ps
module tpm_unit_test;
  localparam int NCH = 4;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]       clk_sel = '0;
  logic             center_mode = 1'b0;
  logic             ext_clk = 1'b0;
  logic [W-1:0]     modulo = '0;
  logic             ovf_clr = 1'b0;
  logic [2*NCH-1:0] ch_mode = '0, ch_edge = '0;
  logic [NCH-1:0]   ch_val_we = '0, ch_flag_clr = '0, ch_pin_in = '0;
  logic [NCH*W-1:0] ch_val_wdata = '0;
  logic [W-1:0]     count;
  logic             ovf_flag;
  logic [NCH*W-1:0] ch_val;
  logic [NCH-1:0]   ch_flag, ch_pin_out, ch_pin_oe;

  tpm_unit #(.NCH(NCH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .center_mode(center_mode),
    .ext_clk(ext_clk), .modulo(modulo), .count(count), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr), .ch_mode(ch_mode), .ch_edge(ch_edge), .ch_val_we(ch_val_we),
    .ch_val_wdata(ch_val_wdata), .ch_val(ch_val), .ch_flag(ch_flag),
    .ch_flag_clr(ch_flag_clr), .ch_pin_in(ch_pin_in), .ch_pin_out(ch_pin_out),
    .ch_pin_oe(ch_pin_oe)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  int m_cnt;
  bit m_down, m_ovf;
  int m_val[NCH];
  bit m_flag[NCH], m_pin[NCH];
  bit m_e[3];
  bit m_p[NCH][3];

  always @(posedge clk) begin
    bit tk, top, oev, nd, own, r, f, mt, cp, ev;
    int nc, md, el;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_ovf = 0;
      for (int i = 0; i < 3; i++) m_e[i] = 0;
      for (int i = 0; i < NCH; i++) begin
        m_val[i] = 0; m_flag[i] = 0; m_pin[i] = 0;
        for (int k = 0; k < 3; k++) m_p[i][k] = 0;
      end
    end else begin
      tk  = (clk_sel == 2'd1) || (clk_sel == 2'd3 && m_e[1] && !m_e[2]);
      top = m_cnt >= int'(modulo);
      nc = m_cnt; nd = m_down; oev = 0;
      if (!center_mode) begin
        nd = 0;
        if (tk) begin
          if (top) begin nc = 0; oev = 1; end
          else nc = m_cnt + 1;
        end
      end else if (tk) begin
        if (modulo == 0) begin nc = 0; nd = 0; oev = 1; end
        else if (!m_down) begin
          if (top) begin nd = 1; nc = m_cnt - 1; end
          else nc = m_cnt + 1;
        end else if (m_cnt == 0) begin nd = 0; nc = 1; oev = 1; end
        else nc = m_cnt - 1;
      end
      for (int i = 0; i < NCH; i++) begin
        md  = int'(ch_mode[2*i +: 2]);
        el  = int'(ch_edge[2*i +: 2]);
        own = (clk_sel != 0) && (el != 0);
        r   = m_p[i][1] && !m_p[i][2];
        f   = !m_p[i][1] && m_p[i][2];
        mt  = tk && (m_cnt == m_val[i]);
        cp  = !center_mode && md == 0 && own &&
              ((el == 1 && r) || (el == 2 && f) || (el == 3 && (r || f)));
        ev  = cp || (mt && (center_mode || md != 0));
        if (center_mode) begin
          if (mt) m_pin[i] = !m_pin[i];
        end else if (md == 1) begin
          if (mt) begin
            if (el == 1) m_pin[i] = !m_pin[i];
            else if (el == 2) m_pin[i] = 0;
            else if (el == 3) m_pin[i] = 1;
          end
        end else if (md >= 2) begin
          if (tk && top) m_pin[i] = (el % 2) == 0;
          else if (mt) m_pin[i] = (el % 2) == 1;
        end
        if (cp) m_val[i] = m_cnt;
        else if (ch_val_we[i]) m_val[i] = int'(ch_val_wdata[i*W +: W]);
        m_flag[i] = ev || (m_flag[i] && !ch_flag_clr[i]);
        m_p[i][2] = m_p[i][1]; m_p[i][1] = m_p[i][0]; m_p[i][0] = ch_pin_in[i];
      end
      m_e[2] = m_e[1]; m_e[1] = m_e[0]; m_e[0] = ext_clk;
      m_cnt = nc; m_down = nd;
      m_ovf = oev || (m_ovf && !ovf_clr);
    end
  end

  function automatic string mode_tag(int i);
    if (center_mode) return "R9";
    if (ch_mode[2*i +: 2] == 2'd0) return "R6";
    if (ch_mode[2*i +: 2] == 2'd1) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clk_sel != 2'd1 ? "R1" : (center_mode ? "R3" : "R2"), "count", 32'(count), 32'(m_cnt));
      check("R4", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
      for (int i = 0; i < NCH; i++) begin
        check("R5", "pin_oe", 32'(ch_pin_oe[i]),
              32'((clk_sel != 0) && (ch_edge[2*i +: 2] != 0)));
        check(mode_tag(i), "pin_out", 32'(ch_pin_out[i]), 32'(m_pin[i]));
        check(mode_tag(i), "flag", 32'(ch_flag[i]), 32'(m_flag[i]));
        check("R6", "value", 32'(ch_val[i*W +: W]), 32'(m_val[i]));
      end
    end
  end

  initial begin
    forever begin
      repeat (4) @(posedge clk);
      #1 ext_clk = ~ext_clk;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_ch(int i, int md, int el);
    ch_mode[2*i +: 2] = 2'(md);
    ch_edge[2*i +: 2] = 2'(el);
  endtask

  task automatic write_val(int i, int v);
    ch_val_we[i] = 1'b1;
    ch_val_wdata[i*W +: W] = W'(v);
    step(1);
    ch_val_we[i] = 1'b0;
    @(negedge clk);
    check("R10", "written value", 32'(ch_val[i*W +: W]), 32'(v));
    step(0);
  endtask

  task automatic pulse_pin(int i, int hi, int lo);
    ch_pin_in[i] = 1'b1; step(hi);
    ch_pin_in[i] = 1'b0; step(lo);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    check("R11", "reset count", 32'(count), 0);
    check("R11", "reset ovf", 32'(ovf_flag), 0);
    check("R11", "reset values", 32'(|ch_val), 0);
    check("R11", "reset flags/pins", 32'({ch_flag, ch_pin_out}), 0);
    step(0);
    rst_n = 1'b1;

    // up-count: compare toggle, two PWM polarities, capture on both edges
    clk_sel = 2'd1; modulo = 16'd9;
    set_ch(0, 1, 1); set_ch(1, 2, 2); set_ch(2, 3, 1); set_ch(3, 0, 3);
    write_val(0, 3); write_val(1, 4); write_val(2, 6);
    step(10); pulse_pin(3, 7, 8);
    ch_flag_clr = '1; step(1); ch_flag_clr = '0;
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    step(12);

    // compare clear, set, flag-only
    set_ch(0, 1, 2); step(15);
    set_ch(0, 1, 3); step(15);
    set_ch(0, 1, 0); step(15);
    ch_flag_clr = '1; step(30); ch_flag_clr = '0;

    // capture edge selections
    set_ch(3, 0, 1); pulse_pin(3, 5, 6); pulse_pin(3, 3, 9);
    set_ch(3, 0, 2); pulse_pin(3, 4, 7); pulse_pin(3, 6, 5);
    set_ch(3, 0, 3);
    for (int k = 0; k < 8; k++) begin
      ch_pin_in[3] = ~ch_pin_in[3];
      ch_val_we[3] = 1'b1;
      ch_val_wdata[3*W +: W] = W'(100 + k);
      step(1);
    end
    ch_val_we[3] = 1'b0;
    step(6);

    // modulo cut below running count
    modulo = 16'd200; step(60);
    modulo = 16'd20;  step(30);

    // center-aligned
    modulo = 16'd7; center_mode = 1'b1;
    write_val(0, 2); write_val(1, 5); write_val(2, 7);
    for (int k = 0; k < 6; k++) pulse_pin(3, 3, 4);
    ovf_clr = 1'b1; step(2); ovf_clr = 1'b0;
    step(30);

    // zero modulo in both counter modes
    modulo = '0; step(8);
    center_mode = 1'b0; step(8);

    // external clock source
    modulo = 16'd9; clk_sel = 2'd3;
    for (int k = 0; k < 4; k++) pulse_pin(3, 11, 13);
    step(30);

    // stopped source codes
    clk_sel = 2'd0; pulse_pin(3, 4, 6); step(5);
    clk_sel = 2'd2; pulse_pin(3, 4, 6);
    step(4);
    finish_run();
  end
endmodule